// File: doc/BRIEF.md
# UART Receive Queue Controller

This block sits behind a serial receiver's deserializer and holds incoming characters in a 32-entry first-in, first-out queue until firmware collects them through a small register port. It tells the processor when work is waiting in two ways. A fill-level interrupt fires once the queue holds at least a chosen number of characters. An idle interrupt fires when characters sit unread and the line has been quiet for a programmed number of bit times.

The same fill level drives the request-to-send output, so a remote transmitter is paused before the queue runs out of room. Software can choose the pin's polarity, or take direct control of the pin. The receiver reports parity, framing and break conditions with each character. These, and any overrun, are latched in sticky flags that firmware clears by writing ones.

The character input is a valid strobe with no ready signal, because a serial line cannot be stalled. Back-pressure reaches the remote end only through the request-to-send pin. A character offered while the queue is full and no read frees a slot is dropped.

Top module: `uart_rxq_ctrl`

## Requirements
- R1: Characters are returned in arrival order from a 32-entry queue. Reading the DATA register (address 0) removes the oldest character. STATUS (address 3) reports the occupancy in bits [5:0], empty in bit 6 and full in bit 7.
- R2: STATUS bit 12 (fill pending) is 1 while the occupancy is at least the threshold selected by CTRL[3:0]. Codes 0, 1, 2, 3 and 4 select 1, 4, 8, 14 and 30 characters, and any code above 4 selects 30.
- R3: When CTRL[11] is 1 and the queue is not empty, STATUS bit 13 (idle timeout) becomes 1 after TOUT (address 4, bits [7:0]) bit-time ticks with no character written or read. Any write or read restarts the count. The flag stays 0 while CTRL[11] is 0 or the queue is empty.
- R4: When CTRL[8] is 1, the flow request is asserted while the occupancy is below the threshold coded by CTRL[7:4], using the R2 table, and is withdrawn at or above it. With CTRL[9] at 1 an asserted request drives rts_n_o high; with CTRL[9] at 0 it drives the pin low.
- R5: When CTRL[8] is 0, the flow request equals CTRL[10], and the pin polarity is set by CTRL[9] as in R4.
- R6: STATUS bits 8, 9, 10 and 11 hold the sticky parity, framing, break and overflow flags. A flag is set by a valid strobe carrying that error and is cleared by writing 1 to its bit in STATUS. A set and a clear in the same cycle leave the flag set.
- R7: A character offered while the queue is full, with no read in the same cycle, is discarded and sets the overflow flag. The stored characters and the occupancy are unchanged.
- R8: Writing CTRL with bit 16 at 1 empties the queue and leaves the error flags as they were. A character offered in that same cycle is dropped.
- R9: Reading DATA while the queue is empty returns the last character read and leaves the occupancy at 0.
- R10: irq_o is the OR of: INTEN[0] with fill pending, INTEN[1] with idle timeout, INTEN[2] with any of parity, framing or break, and INTEN[3] with overflow. INTEN is at address 2.
- R11: After reset, STATUS reads 0x40, CTRL and INTEN read 0, TOUT reads 0x40, DATA reads 0, rts_n_o is 1 and irq_o is 0.
- R12: A character offered while the queue is full, in the same cycle as a DATA read, is stored, and the occupancy stays at 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of DATA removes a character |
| reg_addr | input | 3 | Register address (0 DATA, 1 CTRL, 2 INTEN, 3 STATUS, 4 TOUT) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| chr_valid | input | 1 | Received character strobe |
| chr_data | input | 8 | Received character |
| chr_perr | input | 1 | Parity error for this character |
| chr_ferr | input | 1 | Framing error for this character |
| chr_brk | input | 1 | Break detected with this character |
| bit_tick | input | 1 | One pulse per bit time |
| rts_n_o | output | 1 | Request-to-send pin |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can meet in one cycle, and both are provoked on purpose. First, a character strobe arrives while the queue is full, in the same cycle as a DATA read. The bench then expects the occupancy to stay at 32 and the late character to come out last when the queue is drained. Second, a character carrying a parity error arrives in the same cycle as a write-one-to-clear of the parity flag. The flag must still read 1 afterwards, and a later clear on its own must remove it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_IEN  = 3'd2;
  localparam logic [2:0] ADDR_STAT = 3'd3;
  localparam logic [2:0] ADDR_TOUT = 3'd4;
  localparam int FLUSH_BIT = 16;

  typedef struct packed {
    logic       to_en;
    logic       sw_rts;
    logic       rts_hi;
    logic       auto_rts;
    logic [3:0] rts_code;
    logic [3:0] rx_code;
  } rxq_ctrl_t;

  function automatic int unsigned trig_level(input logic [3:0] code);
    case (code)
      4'd0:    return 1;
      4'd1:    return 4;
      4'd2:    return 8;
      4'd3:    return 14;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (32'(count) == DEPTH);
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          active,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt <= '0;
    else if (restart || !enable || !active)  cnt <= '0;
    else if (tick && cnt < limit)            cnt <= cnt + 1'b1;
  end

  assign expired = enable && active && (cnt >= limit);
endmodule

// File: rtl/rxq_rts_gen.sv
module rxq_rts_gen #(
  parameter int CNT_W = 6
) (
  input  logic             auto_en,
  input  logic             act_hi,
  input  logic             sw_req,
  input  logic [3:0]       code,
  input  logic [CNT_W-1:0] count,
  output logic             rts_pin
);
  import rxq_pkg::*;
  logic req;

  always_comb begin
    if (auto_en) req = (32'(count) < trig_level(code));
    else         req = sw_req;
    rts_pin = act_hi ? req : ~req;
  end
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int DW       = 8,
  parameter int TW       = 8,
  parameter int TOUT_RST = 64,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          chr_valid,
  input  logic [DW-1:0] chr_data,
  input  logic          chr_perr,
  input  logic          chr_ferr,
  input  logic          chr_brk,
  input  logic          bit_tick,
  output logic          rts_n_o,
  output logic          irq_o
);
  rxq_ctrl_t        ctrl_q;
  logic [3:0]       ien_q;
  logic [TW-1:0]    tout_q;
  logic [DW-1:0]    hold_q, head;
  logic             perr_q, ferr_q, brk_q, ovf_q;
  logic [CNT_W-1:0] count;
  logic             empty, full, pop_req, push_ok, flush_req, w1c, ovf_evt;
  logic             fill_pend, rto;
  logic             unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:17], reg_wdata[15:12]};

  assign flush_req = reg_wr && reg_addr == ADDR_CTRL && reg_wdata[FLUSH_BIT];
  assign pop_req   = reg_rd && reg_addr == ADDR_DATA && !empty;
  assign push_ok   = chr_valid && !flush_req && (!full || pop_req);
  assign ovf_evt   = chr_valid && !flush_req && full && !pop_req;
  assign w1c       = reg_wr && reg_addr == ADDR_STAT;

  rxq_fifo #(.DEPTH(DEPTH), .DW(DW)) i_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_req), .flush(flush_req),
    .wdata(chr_data), .head(head), .count(count), .empty(empty), .full(full)
  );

  rxq_idle_timer #(.TW(TW)) i_timer (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .enable(ctrl_q.to_en),
    .active(!empty), .restart(push_ok || pop_req || flush_req),
    .limit(tout_q), .expired(rto)
  );

  rxq_rts_gen #(.CNT_W(CNT_W)) i_rts (
    .auto_en(ctrl_q.auto_rts), .act_hi(ctrl_q.rts_hi), .sw_req(ctrl_q.sw_rts),
    .code(ctrl_q.rts_code), .count(count), .rts_pin(rts_n_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      tout_q <= TW'(TOUT_RST);
      hold_q <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= rxq_ctrl_t'(reg_wdata[11:0]);
      if (reg_wr && reg_addr == ADDR_IEN)  ien_q  <= reg_wdata[3:0];
      if (reg_wr && reg_addr == ADDR_TOUT) tout_q <= reg_wdata[TW-1:0];
      if (pop_req) hold_q <= head;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      brk_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      perr_q <= (perr_q && !(w1c && reg_wdata[8]))  || (chr_valid && chr_perr);
      ferr_q <= (ferr_q && !(w1c && reg_wdata[9]))  || (chr_valid && chr_ferr);
      brk_q  <= (brk_q  && !(w1c && reg_wdata[10])) || (chr_valid && chr_brk);
      ovf_q  <= (ovf_q  && !(w1c && reg_wdata[11])) || ovf_evt;
    end
  end

  assign fill_pend = (32'(count) >= trig_level(ctrl_q.rx_code));
  assign irq_o = (ien_q[0] && fill_pend) || (ien_q[1] && rto) ||
                 (ien_q[2] && (perr_q || ferr_q || brk_q)) || (ien_q[3] && ovf_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_DATA: reg_rdata[DW-1:0] = empty ? hold_q : head;
      ADDR_CTRL: reg_rdata[11:0]   = ctrl_q;
      ADDR_IEN:  reg_rdata[3:0]    = ien_q;
      ADDR_STAT: begin
        reg_rdata[CNT_W-1:0] = count;
        reg_rdata[13:6] = {rto, fill_pend, ovf_q, brk_q, ferr_q, perr_q, full, empty};
      end
      ADDR_TOUT: reg_rdata[TW-1:0] = tout_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             chr_valid,
  input logic             pop_req,
  input logic             flush_req,
  input logic [CNT_W-1:0] count,
  input logic             empty,
  input logic             full,
  input logic [DW-1:0]    head,
  input logic             ovf_q,
  input logic             rto
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);  // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && chr_valid && !pop_req && !flush_req) |=>
      (32'(count) == DEPTH && $stable(head) && ovf_q));  // R7

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_DATA && empty && !chr_valid) |=> empty);  // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (count == '0));  // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(reg_wr && reg_addr == ADDR_STAT && reg_wdata[11])) |=> ovf_q);  // R6

  AST_TIMEOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rto |-> !empty);  // R3
endmodule

bind uart_rxq_ctrl rxq_chk #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .chr_valid(chr_valid), .pop_req(pop_req),
  .flush_req(flush_req), .count(count), .empty(empty), .full(full), .head(head),
  .ovf_q(ovf_q), .rto(rto)
);

// File: tb/test_uart_rxq_ctrl.sv
`timescale 1ns/100ps
module test_uart_rxq_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        chr_valid = 0, chr_perr = 0, chr_ferr = 0, chr_brk = 0, bit_tick = 0;
  logic [7:0]  chr_data = 0;
  logic        rts_n_o, irq_o;
  int          nvec = 0, nbad = 0;
  bit          done = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  uart_rxq_ctrl i_uart_rxq_ctrl (.*);

  // {code[3:0], fill[5:0], expected fill-pending / rts_n}
  localparam logic [10:0] VEC [12] = '{
    {4'd0, 6'd0, 1'b0}, {4'd0, 6'd1, 1'b1}, {4'd1, 6'd3, 1'b0}, {4'd1, 6'd4, 1'b1},
    {4'd2, 6'd7, 1'b0}, {4'd2, 6'd8, 1'b1}, {4'd3, 6'd13, 1'b0}, {4'd3, 6'd14, 1'b1},
    {4'd4, 6'd29, 1'b0}, {4'd4, 6'd30, 1'b1}, {4'd7, 6'd29, 1'b0}, {4'd7, 6'd30, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic push(input logic [7:0] c, input logic p, input logic f, input logic b);
    @(negedge clk); chr_valid = 1; chr_data = c; chr_perr = p; chr_ferr = f; chr_brk = b;
    @(posedge clk); #1 chr_valid = 0; chr_perr = 0; chr_ferr = 0; chr_brk = 0;
  endtask

  task automatic tick();
    @(negedge clk); bit_tick = 1;
    @(posedge clk); #1 bit_tick = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset state
    rd(3'd3, d); chk("R11 status", d, 32'h40);
    rd(3'd1, d); chk("R11 ctrl", d, 0);
    rd(3'd2, d); chk("R11 inten", d, 0);
    rd(3'd4, d); chk("R11 tout", d, 32'h40);
    rd(3'd0, d); chk("R11 data", d, 0);
    chk("R11 rts_n", rts_n_o, 1); chk("R11 irq", irq_o, 0);

    // R2 / R4 threshold table, shared code for fill trigger and auto flow
    for (int i = 0; i < 12; i++) begin
      wr(3'd1, (32'd1 << 16) | (32'd1 << 8) | (32'(VEC[i][10:7]) << 4) | 32'(VEC[i][10:7]));
      for (int k = 0; k < int'(VEC[i][6:1]); k++) push(8'(k), 0, 0, 0);
      rd(3'd3, d); chk("R2 fill pending", 32'(d[12]), 32'(VEC[i][0]));
      chk("R4 auto rts", 32'(rts_n_o), 32'(VEC[i][0]));
    end

    // R1 ordering
    wr(3'd1, 32'd1 << 16);
    push(8'hA1, 0, 0, 0); push(8'hB2, 0, 0, 0); push(8'hC3, 0, 0, 0);
    rd(3'd3, d); chk("R1 count", d[7:0], 8'h03);
    rd(3'd0, d); chk("R1 first", d, 32'hA1);
    rd(3'd0, d); chk("R1 second", d, 32'hB2);
    rd(3'd0, d); chk("R1 third", d, 32'hC3);
    // R9 empty read
    rd(3'd0, d); chk("R9 empty read value", d, 32'hC3);
    rd(3'd3, d); chk("R9 count stays 0", d[7:0], 8'h40);

    // R7 full and overflow
    for (int k = 0; k < 32; k++) push(8'(k), 0, 0, 0);
    rd(3'd3, d); chk("R1 full flags", d[7:0], 8'hA0);
    push(8'hEE, 0, 0, 0);
    rd(3'd3, d); chk("R7 overflow set", 32'(d[11]), 1); chk("R7 count held", d[7:0], 8'hA0);
    rd(3'd0, d); chk("R7 head unchanged", d, 32'h00);
    push(8'h20, 0, 0, 0);
    // R12 push and read in one cycle while full
    @(negedge clk); chr_valid = 1; chr_data = 8'h77; reg_rd = 1; reg_addr = 3'd0;
    #1 d = reg_rdata;
    @(posedge clk); #1 chr_valid = 0; reg_rd = 0;
    chk("R12 read value", d, 32'h01);
    rd(3'd3, d); chk("R12 count stays full", d[7:0], 8'hA0);
    for (int k = 2; k < 32; k++) rd(3'd0, d);
    rd(3'd0, d); chk("R7 order after drop", d, 32'h20);
    rd(3'd0, d); chk("R12 late char stored", d, 32'h77);

    // R6 write-one-to-clear and set-wins
    wr(3'd3, 32'd1 << 11);
    rd(3'd3, d); chk("R6 ovf cleared", 32'(d[11]), 0);
    @(negedge clk); chr_valid = 1; chr_perr = 1; reg_wr = 1; reg_addr = 3'd3; reg_wdata = 32'd1 << 8;
    @(posedge clk); #1 chr_valid = 0; chr_perr = 0; reg_wr = 0;
    rd(3'd3, d); chk("R6 set wins", 32'(d[8]), 1);
    wr(3'd3, 32'd1 << 8);
    rd(3'd3, d); chk("R6 perr cleared", 32'(d[8]), 0);
    push(8'h11, 0, 1, 1);
    rd(3'd3, d); chk("R6 ferr brk set", 32'(d[11:8]), 32'h6);
    wr(3'd3, 32'h600);
    rd(3'd3, d); chk("R6 ferr brk cleared", 32'(d[11:8]), 0);

    // R10 interrupt combining
    wr(3'd2, 32'h4);
    chk("R10 irq off", irq_o, 0);
    push(8'h12, 1, 0, 0);
    chk("R10 line err irq", irq_o, 1);
    wr(3'd2, 32'h0);
    chk("R10 masked", irq_o, 0);
    wr(3'd3, 32'd1 << 8);

    // R3 idle timeout
    wr(3'd1, 32'd1 << 16);
    wr(3'd4, 32'd5);
    wr(3'd1, 32'd1 << 11);
    wr(3'd2, 32'h2);
    push(8'h55, 0, 0, 0);
    for (int k = 0; k < 4; k++) tick();
    rd(3'd3, d); chk("R3 not yet", 32'(d[13]), 0); chk("R3 irq not yet", irq_o, 0);
    tick();
    rd(3'd3, d); chk("R3 expired", 32'(d[13]), 1); chk("R10 timeout irq", irq_o, 1);
    rd(3'd0, d);
    rd(3'd3, d); chk("R3 cleared by read", 32'(d[13]), 0);
    wr(3'd1, 32'd0);
    push(8'h56, 0, 0, 0);
    for (int k = 0; k < 6; k++) tick();
    rd(3'd3, d); chk("R3 disabled", 32'(d[13]), 0);
    wr(3'd2, 32'h0);

    // R8 flush beats a push, keeps error flags
    push(8'h57, 0, 0, 1);
    @(negedge clk); chr_valid = 1; chr_data = 8'h58; reg_wr = 1; reg_addr = 3'd1; reg_wdata = 32'd1 << 16;
    @(posedge clk); #1 chr_valid = 0; reg_wr = 0;
    rd(3'd3, d); chk("R8 flushed", d[7:0], 8'h40); chk("R8 brk kept", 32'(d[10]), 1);

    // R5 manual flow control and polarity
    wr(3'd1, (32'd1 << 10) | (32'd1 << 9)); chk("R5 sw hi", rts_n_o, 1);
    wr(3'd1, 32'd1 << 9);                   chk("R5 off hi", rts_n_o, 0);
    wr(3'd1, 32'd1 << 10);                  chk("R5 sw lo", rts_n_o, 0);
    wr(3'd1, 32'd0);                        chk("R5 off lo", rts_n_o, 1);
    // R4 active-high polarity under auto
    wr(3'd1, (32'd1 << 8) | (32'd1 << 9));  chk("R4 hi requesting", rts_n_o, 1);
    push(8'h59, 0, 0, 0);                   chk("R4 hi withdrawn", rts_n_o, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule